// File: doc/BRIEF.md
# Local Interrupt Controller Error Status Logic

This block watches the interrupt requests that a local interrupt controller sends and receives. Each request carries an 8-bit vector and a 3-bit delivery mode. Vectors 0 to 15 are reserved. A fixed-mode or lowest-priority request that names a reserved vector is refused, and an error bit is raised instead. Errors are not written straight into the status register that software reads. They collect in a hidden pending register. A software write to the status register moves them into view and clears the pending set.

An error-entry register holds a mask bit and an 8-bit vector. It decides whether an error interrupt request leaves the block and which vector that request carries. A two-state machine makes sure only one error interrupt is triggered per arming. The state `ARM_READY` moves to `ARM_SPENT` on the transition "trigger", which happens in any cycle that detects an error. `ARM_SPENT` moves back to `ARM_READY` on the transition "rearm", which is an accepted status write in a cycle with no new error. If an accepted status write and a new error arrive in the same cycle, the transition is "rearm-and-trigger": the machine stays in `ARM_SPENT`, and that error is the trigger for the new arming. With the parameter `LOWPRI_OK` cleared, the block models a controller without lowest-priority delivery.

Top module: `esr_top`

## Requirements
- R1: A request in fixed mode (mode code 3'b000) with a vector below 16 is refused. Its accept output is low while it is presented.
- R2: A refused received request sets status bit 6. A refused sent request sets status bit 5.
- R3: With `LOWPRI_OK`=1, lowest-priority mode (mode code 3'b001) is checked in both directions exactly as fixed mode is.
- R4: With `LOWPRI_OK`=0, a sent lowest-priority request with a reserved vector is refused and sets only bit 4. A received lowest-priority request is accepted and raises no error.
- R5: A detected error does not change the visible status, which reads on `rd_data[7:0]` with `rd_addr`=0, until software writes the status register.
- R6: An accepted status write (`wr_addr`=0) copies the pending errors into the visible status and clears the pending set. The data value written has no effect.
- R7: An error interrupt request is a one-cycle pulse on `err_irq_valid` in the cycle after the error is detected. At most one pulse is issued per arming, and an accepted status write rearms.
- R8: The error entry is at `wr_addr`/`rd_addr`=1, with its vector in bits 7:0 and its mask in bit 16. While the mask is set, no pulse is issued, but a detected error still uses up the arming.
- R9: `err_irq_vector` carries bits 7:0 of the error entry.
- R10: While `ext_mode` is high, a nonzero status write is rejected completely: nothing is copied, nothing is cleared and nothing is rearmed. A zero write is accepted.
- R11: An error detected in the same cycle as an accepted status write goes into the new pending set, not into the value just copied. It triggers the new arming.
- R12: After reset the visible status and the pending set are zero, the interrupt is armed, and the error entry reads 32'h0001_0000.
- R13: Vectors of 16 and above, and mode codes other than 3'b000 and 3'b001, are accepted and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | Extended register mode: only zero may be written to the status register |
| snd_valid | input | 1 | Outgoing request present |
| snd_vector | input | 8 | Outgoing request vector |
| snd_mode | input | 3 | Outgoing delivery mode |
| snd_accept | output | 1 | Outgoing request may proceed |
| rcv_valid | input | 1 | Incoming request present |
| rcv_vector | input | 8 | Incoming request vector |
| rcv_mode | input | 3 | Incoming delivery mode |
| rcv_accept | output | 1 | Incoming request may proceed |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 status, 1 error entry |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read target: 0 status, 1 error entry |
| rd_data | output | 32 | Read data (combinational) |
| err_irq_valid | output | 1 | Error interrupt request pulse |
| err_irq_vector | output | 8 | Vector of the error interrupt request |

## Verification
A wrong arming state shows up as a missing or extra pulse on `err_irq_valid`. That pulse comes one cycle after the first error following a status write, so a state fault is visible within two cycles of the next error. Faults in the pending or visible registers stay hidden until the next accepted status write. The bench therefore follows every error scenario with a write and a read, so a lost, duplicated or early bit appears at the read right after that write. The same-cycle write-and-error case and the rejected extended-mode write each get their own write-and-read sequence, because only there does the order of copy and capture show.

// File: rtl/esr_pkg.sv
package esr_pkg;
    localparam int ESR_W        = 8;
    localparam int MODE_W       = 3;
    localparam int BIT_REDIR    = 4;
    localparam int BIT_SEND     = 5;
    localparam int BIT_RECV     = 6;
    localparam int LVT_MASK_BIT = 16;
    localparam logic [MODE_W-1:0] MODE_FIXED  = 3'b000;
    localparam logic [MODE_W-1:0] MODE_LOWPRI = 3'b001;

    typedef enum logic {
        ARM_READY = 1'b0,
        ARM_SPENT = 1'b1
    } arm_state_e;
endpackage

// File: rtl/esr_detect.sv
module esr_detect
    import esr_pkg::*;
#(
    parameter bit IS_SEND    = 1'b1,
    parameter bit LOWPRI_OK  = 1'b1,
    parameter int VEC_W      = 8,
    parameter int RSVD_LIMIT = 16
) (
    input  logic              valid,
    input  logic [VEC_W-1:0]  vector,
    input  logic [MODE_W-1:0] mode,
    output logic              accept,
    output logic [ESR_W-1:0]  err
);
    localparam int ILL_BIT = IS_SEND ? BIT_SEND : BIT_RECV;

    logic reserved;
    logic fixed_bad;
    logic lp_bad;
    logic lp_ill;
    logic lp_redir;

    assign reserved  = vector < VEC_W'(RSVD_LIMIT);
    assign fixed_bad = valid && reserved && (mode == MODE_FIXED);
    assign lp_bad    = valid && reserved && (mode == MODE_LOWPRI);

    generate
        if (LOWPRI_OK) begin : g_lp_same
            assign lp_ill   = lp_bad;
            assign lp_redir = 1'b0;
        end else if (IS_SEND) begin : g_lp_redir
            assign lp_ill   = 1'b0;
            assign lp_redir = lp_bad;
        end else begin : g_lp_free
            assign lp_ill   = 1'b0;
            assign lp_redir = 1'b0;
        end
    endgenerate

    always_comb begin
        err            = '0;
        err[ILL_BIT]   = fixed_bad || lp_ill;
        err[BIT_REDIR] = lp_redir;
    end

    assign accept = valid && !(fixed_bad || lp_ill || lp_redir);
endmodule

// File: rtl/esr_regs.sv
module esr_regs
    import esr_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_status,
    input  logic             wr_entry,
    input  logic [VEC_W-1:0] entry_vec_in,
    input  logic             entry_mask_in,
    input  logic [ESR_W-1:0] err_now,
    output logic [ESR_W-1:0] vis_q,
    output logic [ESR_W-1:0] pend_q,
    output logic [VEC_W-1:0] entry_vec_q,
    output logic             entry_mask_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vis_q        <= '0;
            pend_q       <= '0;
            entry_vec_q  <= '0;
            entry_mask_q <= 1'b1;
        end else begin
            if (wr_status) begin
                vis_q  <= pend_q;
                pend_q <= err_now;
            end else begin
                pend_q <= pend_q | err_now;
            end
            if (wr_entry) begin
                entry_vec_q  <= entry_vec_in;
                entry_mask_q <= entry_mask_in;
            end
        end
    end

    // R5
    vis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_status |=> $stable(vis_q));

    // R6
    pend_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_status |=> (vis_q == $past(pend_q)) && (pend_q == $past(err_now)));
endmodule

// File: rtl/esr_arm_fsm.sv
module esr_arm_fsm
    import esr_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ok,
    input  logic             err_any,
    input  logic             entry_mask,
    input  logic [VEC_W-1:0] entry_vec,
    output logic             irq_valid_q,
    output logic [VEC_W-1:0] irq_vector_q
);
    arm_state_e state_q;
    arm_state_e state_d;
    logic       fire;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_READY: if (err_any) state_d = ARM_SPENT;
            ARM_SPENT: if (wr_ok && !err_any) state_d = ARM_READY;
            default:   state_d = ARM_READY;
        endcase
    end

    assign fire = err_any && !entry_mask && ((state_q == ARM_READY) || wr_ok);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARM_READY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid_q  <= 1'b0;
            irq_vector_q <= '0;
        end else begin
            irq_valid_q  <= fire;
            irq_vector_q <= entry_vec;
        end
    end

    // R7
    spent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARM_SPENT && !wr_ok) |=> !irq_valid_q);

    // R7
    pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_q |-> (state_q == ARM_SPENT));

    // R8
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_q |-> !$past(entry_mask));
endmodule

// File: rtl/esr_top.sv
module esr_top
    import esr_pkg::*;
#(
    parameter bit LOWPRI_OK  = 1'b1,
    parameter int VEC_W      = 8,
    parameter int DATA_W     = 32,
    parameter int RSVD_LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_mode,
    input  logic              snd_valid,
    input  logic [VEC_W-1:0]  snd_vector,
    input  logic [MODE_W-1:0] snd_mode,
    output logic              snd_accept,
    input  logic              rcv_valid,
    input  logic [VEC_W-1:0]  rcv_vector,
    input  logic [MODE_W-1:0] rcv_mode,
    output logic              rcv_accept,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_irq_valid,
    output logic [VEC_W-1:0]  err_irq_vector
);
    logic [ESR_W-1:0] snd_err;
    logic [ESR_W-1:0] rcv_err;
    logic [ESR_W-1:0] err_now;
    logic [ESR_W-1:0] vis_q;
    logic [ESR_W-1:0] pend_q;
    logic [VEC_W-1:0] entry_vec_q;
    logic             entry_mask_q;
    logic             wr_status_ok;
    logic             wr_entry;

    esr_detect #(.IS_SEND(1'b1), .LOWPRI_OK(LOWPRI_OK), .VEC_W(VEC_W), .RSVD_LIMIT(RSVD_LIMIT)) u_snd (
        .valid(snd_valid), .vector(snd_vector), .mode(snd_mode),
        .accept(snd_accept), .err(snd_err)
    );

    esr_detect #(.IS_SEND(1'b0), .LOWPRI_OK(LOWPRI_OK), .VEC_W(VEC_W), .RSVD_LIMIT(RSVD_LIMIT)) u_rcv (
        .valid(rcv_valid), .vector(rcv_vector), .mode(rcv_mode),
        .accept(rcv_accept), .err(rcv_err)
    );

    assign err_now      = snd_err | rcv_err;
    assign wr_status_ok = wr_en && !wr_addr && !(ext_mode && (wr_data != '0));
    assign wr_entry     = wr_en && wr_addr;

    esr_regs #(.VEC_W(VEC_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_status(wr_status_ok), .wr_entry(wr_entry),
        .entry_vec_in(wr_data[VEC_W-1:0]), .entry_mask_in(wr_data[LVT_MASK_BIT]),
        .err_now(err_now), .vis_q(vis_q), .pend_q(pend_q),
        .entry_vec_q(entry_vec_q), .entry_mask_q(entry_mask_q)
    );

    esr_arm_fsm #(.VEC_W(VEC_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .wr_ok(wr_status_ok), .err_any(|err_now),
        .entry_mask(entry_mask_q), .entry_vec(entry_vec_q),
        .irq_valid_q(err_irq_valid), .irq_vector_q(err_irq_vector)
    );

    always_comb begin
        rd_data = '0;
        if (!rd_addr) begin
            rd_data[ESR_W-1:0] = vis_q;
        end else begin
            rd_data[VEC_W-1:0]     = entry_vec_q;
            rd_data[LVT_MASK_BIT]  = entry_mask_q;
        end
    end

    // R1
    fixed_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_valid && snd_mode == MODE_FIXED && snd_vector < VEC_W'(RSVD_LIMIT)) |-> !snd_accept);

    // R10
    ext_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr && ext_mode && wr_data != '0 && err_now == '0) |=> $stable(vis_q) && $stable(pend_q));

    // R12
    pend_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|pend_q) |-> $past(|err_now));
endmodule

// File: tb/tb_esr_top.sv
`timescale 1ns/1ps
module tb_esr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_mode = 1'b0;
    logic        snd_valid = 1'b0;
    logic [7:0]  snd_vector = '0;
    logic [2:0]  snd_mode = '0;
    logic        rcv_valid = 1'b0;
    logic [7:0]  rcv_vector = '0;
    logic [2:0]  rcv_mode = '0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_addr = 1'b0;
    logic        snd_accept, rcv_accept, snd_accept2, rcv_accept2;
    logic [31:0] rd_data, rd_data2;
    logic        err_irq_valid, irq2_valid;
    logic [7:0]  err_irq_vector, irq2_vector;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    esr_top dut (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode),
        .snd_valid(snd_valid), .snd_vector(snd_vector), .snd_mode(snd_mode), .snd_accept(snd_accept),
        .rcv_valid(rcv_valid), .rcv_vector(rcv_vector), .rcv_mode(rcv_mode), .rcv_accept(rcv_accept),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .err_irq_valid(err_irq_valid), .err_irq_vector(err_irq_vector)
    );

    esr_top #(.LOWPRI_OK(1'b0)) dut_nolp (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode),
        .snd_valid(snd_valid), .snd_vector(snd_vector), .snd_mode(snd_mode), .snd_accept(snd_accept2),
        .rcv_valid(rcv_valid), .rcv_vector(rcv_vector), .rcv_mode(rcv_mode), .rcv_accept(rcv_accept2),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data2),
        .err_irq_valid(irq2_valid), .err_irq_vector(irq2_vector)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one-cycle request; returns accept sampled while presented
    task automatic pulse_req(input bit is_send, input logic [7:0] vec, input logic [2:0] mode,
                             output logic acc, output logic acc2);
        @(negedge clk);
        if (is_send) begin snd_valid = 1'b1; snd_vector = vec; snd_mode = mode; end
        else         begin rcv_valid = 1'b1; rcv_vector = vec; rcv_mode = mode; end
        #1;
        acc  = is_send ? snd_accept  : rcv_accept;
        acc2 = is_send ? snd_accept2 : rcv_accept2;
        @(negedge clk);
        snd_valid = 1'b0;
        rcv_valid = 1'b0;
    endtask

    task automatic wr(input logic addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic addr, output logic [31:0] d, output logic [31:0] d2);
        rd_addr = addr;
        #1;
        d  = rd_data;
        d2 = rd_data2;
    endtask

    task automatic t_reset();
        logic [31:0] d, d2;
        rd(1'b0, d, d2);
        check("R12 status after reset", d, 32'h0);
        rd(1'b1, d, d2);
        check("R12 entry after reset", d, 32'h0001_0000);
        check("R12 no irq after reset", {31'b0, err_irq_valid}, 32'h0);
    endtask

    task automatic t_first_error();
        logic a, a2;
        logic [31:0] d, d2;
        wr(1'b1, 32'h0000_0033);
        rd(1'b1, d, d2);
        check("R8 entry unmasked", d, 32'h0000_0033);
        pulse_req(1'b0, 8'd5, 3'b000, a, a2);
        check("R1 recv fixed 5 refused", {31'b0, a}, 32'h0);
        check("R7 irq pulse after error", {31'b0, err_irq_valid}, 32'h1);
        check("R9 irq vector", {24'b0, err_irq_vector}, 32'h33);
        rd(1'b0, d, d2);
        check("R5 status hidden", d, 32'h0);
        @(negedge clk);
        check("R7 pulse one cycle", {31'b0, err_irq_valid}, 32'h0);
        pulse_req(1'b1, 8'd3, 3'b000, a, a2);
        check("R1 send fixed 3 refused", {31'b0, a}, 32'h0);
        check("R7 no second irq", {31'b0, err_irq_valid}, 32'h0);
    endtask

    task automatic t_copy();
        logic [31:0] d, d2;
        wr(1'b0, 32'h0000_00FF);
        rd(1'b0, d, d2);
        check("R2 R6 copied send+recv bits", d, 32'h60);
        wr(1'b0, 32'h0);
        rd(1'b0, d, d2);
        check("R6 pending cleared", d, 32'h0);
    endtask

    task automatic t_legal();
        logic a, a2;
        logic [31:0] d, d2;
        pulse_req(1'b1, 8'h40, 3'b000, a, a2);
        check("R13 legal vector accepted", {31'b0, a}, 32'h1);
        check("R13 no irq legal", {31'b0, err_irq_valid}, 32'h0);
        pulse_req(1'b0, 8'd2, 3'b100, a, a2);
        check("R13 other mode accepted", {31'b0, a}, 32'h1);
        check("R13 no irq other mode", {31'b0, err_irq_valid}, 32'h0);
        wr(1'b0, 32'h0);
        rd(1'b0, d, d2);
        check("R13 no error bits", d, 32'h0);
    endtask

    task automatic t_lowpri();
        logic a, a2;
        logic [31:0] d, d2;
        pulse_req(1'b1, 8'd2, 3'b001, a, a2);
        check("R3 send lowpri refused", {31'b0, a}, 32'h0);
        check("R4 send lowpri refused no-lp", {31'b0, a2}, 32'h0);
        check("R3 irq on lowpri", {31'b0, err_irq_valid}, 32'h1);
        pulse_req(1'b0, 8'd9, 3'b001, a, a2);
        check("R3 recv lowpri refused", {31'b0, a}, 32'h0);
        check("R4 recv lowpri accepted no-lp", {31'b0, a2}, 32'h1);
        wr(1'b0, 32'h0);
        rd(1'b0, d, d2);
        check("R3 lowpri bits", d, 32'h60);
        check("R4 redirect bit only", d2, 32'h10);
    endtask

    task automatic t_mask();
        logic a, a2;
        wr(1'b1, 32'h0001_0044);
        wr(1'b0, 32'h0);
        pulse_req(1'b1, 8'd1, 3'b000, a, a2);
        check("R8 masked no irq", {31'b0, err_irq_valid}, 32'h0);
        wr(1'b1, 32'h0000_0044);
        pulse_req(1'b0, 8'd2, 3'b000, a, a2);
        check("R8 arming used while masked", {31'b0, err_irq_valid}, 32'h0);
        wr(1'b0, 32'h0);
        pulse_req(1'b1, 8'd4, 3'b000, a, a2);
        check("R7 rearmed irq", {31'b0, err_irq_valid}, 32'h1);
        check("R9 new vector", {24'b0, err_irq_vector}, 32'h44);
    endtask

    task automatic t_same_cycle();
        logic [31:0] d, d2;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 1'b0; wr_data = 32'h0;
        rcv_valid = 1'b1; rcv_vector = 8'd7; rcv_mode = 3'b000;
        @(negedge clk);
        wr_en = 1'b0; rcv_valid = 1'b0;
        check("R11 same-cycle error triggers", {31'b0, err_irq_valid}, 32'h1);
        rd(1'b0, d, d2);
        check("R11 copied value excludes new error", d, 32'h20);
        wr(1'b0, 32'h0);
        rd(1'b0, d, d2);
        check("R11 new error kept", d, 32'h40);
    endtask

    task automatic t_ext();
        logic a, a2;
        logic [31:0] d, d2;
        pulse_req(1'b1, 8'd8, 3'b000, a, a2);
        check("R7 irq before ext test", {31'b0, err_irq_valid}, 32'h1);
        ext_mode = 1'b1;
        wr(1'b0, 32'h5);
        rd(1'b0, d, d2);
        check("R10 nonzero write not copied", d, 32'h40);
        pulse_req(1'b0, 8'd3, 3'b000, a, a2);
        check("R10 nonzero write not rearmed", {31'b0, err_irq_valid}, 32'h0);
        wr(1'b0, 32'h0);
        rd(1'b0, d, d2);
        check("R10 zero write accepted, pending kept", d, 32'h60);
        ext_mode = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_error();
        t_copy();
        t_legal();
        t_lowpri();
        t_mask();
        t_same_cycle();
        t_ext();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule